// File: doc/BRIEF.md
# Bidirectional Boundary-Scan Pad Cell

This block sits between one core signal group and one chip pad. It lets a test access controller take over that pad. On the core side it receives an output value and an output enable, and it returns an input value. On the pad side it drives an output value and an output enable, and it receives the pad's input level.

A three-bit scan stage sits on a serial chain. A three-bit update stage sits behind it and holds the values that can be forced onto the pad or into the core. The scan stage samples and shifts on the rising edge of the test clock. The update stage loads on the falling edge. An active-low asynchronous test reset clears both stages.

Two plain control inputs set the behaviour. The routing mode chooses where the pad and core values come from. The scan operation chooses what the stages do on each edge. The cell has no data streams, so there is no valid/ready handshake and no back-pressure. Every input is level-driven control or data, and the state advances on every clock edge.

Top module: `bscan_iocell`

## Requirements
- R1: While `trst_n` is low, both the scan stage and the update stage are zero. They clear as soon as `trst_n` falls, with no clock edge needed. This makes `scan_out` 0 immediately.
- R2: `route_mode` 2'b00 (pass-through) sets `pad_out`=`core_out`, `pad_en`=`core_en` and `core_in`=`pad_in`.
- R3: `route_mode` 2'b11 (pad off) forces `pad_en` to 0, `pad_out`=`core_out` and `core_in`=`pad_in`.
- R4: `route_mode` 2'b01 (drive pad) sets `pad_out` to update bit 1 and `pad_en` to update bit 2, while `core_in`=`pad_in`.
- R5: `route_mode` 2'b10 (drive core) sets `core_in` to update bit 0. The pad side follows the core: `pad_out`=`core_out` and `pad_en`=`core_en`.
- R6: `scan_op` 2'b01 (sample) loads the scan stage on the rising edge of `tck`. Bit 0 takes `pad_in`, bit 1 takes `core_out` and bit 2 takes `core_en`.
- R7: `scan_op` 2'b11 (shift) moves the scan stage on each rising edge. `scan_in` enters bit 0, bit 0 moves to bit 1, and bit 1 moves to bit 2. `scan_out` always shows bit 2.
- R8: `scan_op` 2'b10 (update) copies the scan stage into the update stage on the falling edge of `tck`, not on the rising edge. The scan stage holds its value.
- R9: `scan_op` 2'b00 (idle) holds the scan stage. Every operation other than update leaves the update stage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| route_mode | input | 2 | Routing select (see R2-R5 encodings) |
| scan_op | input | 2 | Scan stage operation (see R6-R9 encodings) |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output (scan bit 2) |
| core_out | input | 1 | Output value from core logic |
| core_en | input | 1 | Output enable from core logic |
| core_in | output | 1 | Input value delivered to core logic |
| pad_in | input | 1 | Level seen at the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_en | output | 1 | Pad driver enable |

## Verification
The hardest situation to reach from the ports is a known pattern in the update stage. That pattern only becomes visible after a run of shifts, one update cycle and a routing change. The stimulus first samples a pad/core pattern and clocks it out to confirm the chain order. It then shifts in a chosen three-bit word, issues an update, and looks at the outputs both between the rising and falling edge and after the falling edge, which shows the update happens on the falling edge. Finally it switches routing between drive-pad and drive-core to read every update bit back at a port.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int unsigned SCAN_W  = 3;
  localparam int unsigned IDX_IN  = 0;
  localparam int unsigned IDX_OUT = 1;
  localparam int unsigned IDX_EN  = 2;
  localparam int unsigned MODE_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    RT_THRU    = 2'b00,
    RT_TO_PAD  = 2'b01,
    RT_TO_CORE = 2'b10,
    RT_PAD_OFF = 2'b11
  } route_mode_e;

  typedef enum logic [MODE_W-1:0] {
    OP_IDLE   = 2'b00,
    OP_SAMPLE = 2'b01,
    OP_UPDATE = 2'b10,
    OP_SHIFT  = 2'b11
  } scan_op_e;

  typedef logic [SCAN_W-1:0] scan_vec_t;

endpackage

// File: rtl/bscan_scan_stage.sv
module bscan_scan_stage
  import bscan_pkg::*;
(
  input  logic      tck,
  input  logic      trst_n,
  input  scan_op_e  op,
  input  scan_vec_t capture_vec,
  input  logic      scan_in,
  output scan_vec_t q
);

  scan_vec_t nxt;

  // Sample and shift act on the rising edge; idle and update hold (R6, R7, R9)
  always_comb begin
    nxt = q;
    unique case (op)
      OP_SAMPLE: nxt = capture_vec;
      OP_SHIFT:  nxt = {q[SCAN_W-2:0], scan_in};
      default:   nxt = q;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) q <= '0;
    else         q <= nxt;
  end

endmodule

// File: rtl/bscan_update_stage.sv
module bscan_update_stage
  import bscan_pkg::*;
(
  input  logic      tck,
  input  logic      trst_n,
  input  logic      load,
  input  scan_vec_t d,
  output scan_vec_t q
);

  // Falling-edge load keeps the value put out stable through the shift edge (R8)
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)   q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/bscan_route_mux.sv
module bscan_route_mux
  import bscan_pkg::*;
(
  input  route_mode_e route,
  input  logic        core_out,
  input  logic        core_en,
  input  logic        pad_in,
  input  scan_vec_t   upd,
  output logic        pad_out,
  output logic        pad_en,
  output logic        core_in
);

  always_comb begin
    pad_out = core_out;
    pad_en  = core_en;
    core_in = pad_in;
    unique case (route)
      RT_TO_PAD: begin
        pad_out = upd[IDX_OUT];
        pad_en  = upd[IDX_EN];
      end
      RT_TO_CORE: core_in = upd[IDX_IN];
      RT_PAD_OFF: pad_en = 1'b0;
      default: ;
    endcase
  end

endmodule

// File: rtl/bscan_iocell.sv
module bscan_iocell
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic [1:0] route_mode,
  input  logic [1:0] scan_op,
  input  logic       scan_in,
  output logic       scan_out,
  input  logic       core_out,
  input  logic       core_en,
  output logic       core_in,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_en
);

  scan_op_e    op;
  route_mode_e route;
  scan_vec_t   cap_vec;
  scan_vec_t   cap_q;
  scan_vec_t   upd_q;

  assign op    = scan_op_e'(scan_op);
  assign route = route_mode_e'(route_mode);

  always_comb begin
    cap_vec          = '0;
    cap_vec[IDX_IN]  = pad_in;
    cap_vec[IDX_OUT] = core_out;
    cap_vec[IDX_EN]  = core_en;
  end

  bscan_scan_stage u_scan (
    .tck         (tck),
    .trst_n      (trst_n),
    .op          (op),
    .capture_vec (cap_vec),
    .scan_in     (scan_in),
    .q           (cap_q)
  );

  bscan_update_stage u_upd (
    .tck    (tck),
    .trst_n (trst_n),
    .load   (op == OP_UPDATE),
    .d      (cap_q),
    .q      (upd_q)
  );

  bscan_route_mux u_route (
    .route    (route),
    .core_out (core_out),
    .core_en  (core_en),
    .pad_in   (pad_in),
    .upd      (upd_q),
    .pad_out  (pad_out),
    .pad_en   (pad_en),
    .core_in  (core_in)
  );

  assign scan_out = cap_q[SCAN_W-1];

endmodule

// File: rtl/bscan_iocell_chk.sv
module bscan_iocell_chk (
  input logic       tck,
  input logic       trst_n,
  input logic [1:0] route_mode,
  input logic [1:0] scan_op,
  input logic       scan_out,
  input logic       core_out,
  input logic       core_en,
  input logic       core_in,
  input logic       pad_in,
  input logic       pad_out,
  input logic       pad_en,
  input logic [2:0] cap_q,
  input logic [2:0] upd_q
);

  AST_RESET_CLEAR: assert property (@(posedge tck) !trst_n |-> (cap_q == 3'b000 && upd_q == 3'b000)); // R1
  AST_THRU_ROUTE: assert property (@(posedge tck) disable iff (!trst_n) route_mode == 2'b00 |-> (pad_out == core_out && pad_en == core_en && core_in == pad_in)); // R2
  AST_PAD_OFF: assert property (@(posedge tck) disable iff (!trst_n) route_mode == 2'b11 |-> (!pad_en && core_in == pad_in)); // R3
  AST_DRIVE_PAD: assert property (@(posedge tck) disable iff (!trst_n) route_mode == 2'b01 |-> (pad_out == upd_q[1] && pad_en == upd_q[2])); // R4
  AST_DRIVE_CORE: assert property (@(posedge tck) disable iff (!trst_n) route_mode == 2'b10 |-> (core_in == upd_q[0] && pad_en == core_en)); // R5
  AST_SAMPLE_CAPT: assert property (@(posedge tck) disable iff (!trst_n) scan_op == 2'b01 |=> cap_q == $past({core_en, core_out, pad_in})); // R6
  AST_SHIFT_OUT: assert property (@(posedge tck) disable iff (!trst_n) scan_op == 2'b11 |=> scan_out == $past(cap_q[1])); // R7
  AST_UPD_LOAD: assert property (@(negedge tck) disable iff (!trst_n) scan_op == 2'b10 |=> upd_q == $past(cap_q)); // R8
  AST_SCAN_HOLD: assert property (@(posedge tck) disable iff (!trst_n) (scan_op == 2'b00 || scan_op == 2'b10) |=> $stable(cap_q)); // R9
  AST_UPD_HOLD: assert property (@(negedge tck) disable iff (!trst_n) scan_op != 2'b10 |=> $stable(upd_q)); // R9

endmodule

bind bscan_iocell bscan_iocell_chk u_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .route_mode (route_mode),
  .scan_op    (scan_op),
  .scan_out   (scan_out),
  .core_out   (core_out),
  .core_en    (core_en),
  .core_in    (core_in),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .pad_en     (pad_en),
  .cap_q      (cap_q),
  .upd_q      (upd_q)
);

// File: tb/bscan_iocell_bench.sv
module bscan_iocell_bench;

  localparam int CLK_HALF = 10; // 50 MHz
  localparam int MAX_CYC  = 200000;

  logic       tck = 1'b0;
  logic       trst_n;
  logic [1:0] route_mode, scan_op;
  logic       scan_in, core_out, core_en, pad_in;
  logic       scan_out, core_in, pad_out, pad_en;

  bscan_iocell u_bscan_iocell (
    .tck(tck), .trst_n(trst_n), .route_mode(route_mode), .scan_op(scan_op),
    .scan_in(scan_in), .scan_out(scan_out), .core_out(core_out), .core_en(core_en),
    .core_in(core_in), .pad_in(pad_in), .pad_out(pad_out), .pad_en(pad_en)
  );

  always #CLK_HALF tck = ~tck;

  typedef struct {
    string      req;
    logic [3:0] exp; // {scan_out, pad_out, pad_en, core_in}
  } item_t;

  item_t queue_q[$];
  event  check_ev;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 0;

  // Model state derived from the requirements
  logic [2:0] sr_m = 3'b000;
  logic [2:0] upd_m = 3'b000;

  function automatic logic [3:0] expected();
    logic po, pe, ci;
    po = core_out; pe = core_en; ci = pad_in;
    case (route_mode)
      2'b01: begin po = upd_m[1]; pe = upd_m[2]; end
      2'b10: ci = upd_m[0];
      2'b11: pe = 1'b0;
      default: ;
    endcase
    return {sr_m[2], po, pe, ci};
  endfunction

  task automatic push(input string req);
    item_t it;
    it.req = req;
    it.exp = expected();
    queue_q.push_back(it);
    ->check_ev;
    #1;
  endtask

  // Monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(check_ev);
      while (queue_q.size() > 0) begin
        item_t it;
        logic [3:0] act;
        it  = queue_q.pop_front();
        act = {scan_out, pad_out, pad_en, core_in};
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b ({scan_out,pad_out,pad_en,core_in})", it.req, act, it.exp);
        end
      end
    end
  end

  // One step: inputs set 5 ns after a falling edge, so one rising and one falling edge follow
  task automatic step(input logic [1:0] rt, input logic [1:0] op, input logic co,
                      input logic ce, input logic pi, input logic si, input string req);
    logic [2:0] old_sr;
    route_mode = rt; scan_op = op; core_out = co; core_en = ce; pad_in = pi; scan_in = si;
    old_sr = sr_m;
    @(posedge tck); #5;
    if (trst_n) begin
      if (op == 2'b01) sr_m = {ce, co, pi};
      else if (op == 2'b11) sr_m = {old_sr[1:0], si};
    end
    if (op == 2'b10) push({req, " (R8 no load on rising edge)"});
    @(negedge tck); #5;
    if (trst_n && op == 2'b10) upd_m = sr_m;
    push(req);
  endtask

  initial begin
    trst_n = 1'b0;
    route_mode = 2'b00; scan_op = 2'b00;
    scan_in = 0; core_out = 0; core_en = 0; pad_in = 0;
    @(negedge tck); #5;
    // R1: reset holds both stages at zero despite sample/update/shift requests
    step(2'b01, 2'b01, 1, 1, 1, 1, "R1");
    step(2'b10, 2'b11, 1, 1, 1, 1, "R1");
    step(2'b01, 2'b10, 1, 1, 1, 1, "R1");
    trst_n = 1'b1;
    #1;
    // R2: pass-through patterns
    step(2'b00, 2'b00, 1, 0, 0, 0, "R2");
    step(2'b00, 2'b00, 0, 1, 1, 0, "R2");
    step(2'b00, 2'b00, 1, 1, 0, 0, "R2");
    // R3: pad off
    step(2'b11, 2'b00, 1, 1, 1, 0, "R3");
    step(2'b11, 2'b00, 0, 1, 0, 0, "R3");
    // R6: sample pad_in=1 core_out=0 core_en=0 -> scan stage 3'b001
    step(2'b00, 2'b01, 0, 0, 1, 0, "R6");
    // R7: shift out, bit 1 then bit 0 reach scan_out
    step(2'b00, 2'b11, 0, 0, 0, 0, "R7");
    step(2'b00, 2'b11, 0, 0, 0, 0, "R7");
    // R6: sample core_out=1 core_en=1 pad_in=0 -> scan_out shows core_en
    step(2'b00, 2'b01, 1, 1, 0, 0, "R6");
    // R7: shift in 1,0,1 -> scan stage 3'b101
    step(2'b01, 2'b11, 0, 0, 0, 1, "R7");
    step(2'b01, 2'b11, 0, 0, 0, 0, "R7");
    step(2'b01, 2'b11, 0, 0, 0, 1, "R7");
    // R8: update on falling edge, visible in drive-pad mode
    step(2'b01, 2'b10, 0, 0, 0, 0, "R8");
    // R4: drive pad from update stage, core_in follows pad
    step(2'b01, 2'b00, 1, 0, 1, 0, "R4");
    step(2'b01, 2'b00, 0, 1, 0, 0, "R4");
    // R5: drive core from update bit 0
    step(2'b10, 2'b00, 0, 1, 0, 0, "R5");
    step(2'b10, 2'b00, 1, 0, 0, 0, "R5");
    // R9: idle holds both stages while inputs toggle
    step(2'b01, 2'b00, 1, 1, 1, 1, "R9");
    // R9: shifting and sampling leave the update stage alone
    step(2'b01, 2'b11, 0, 0, 0, 0, "R9");
    step(2'b01, 2'b01, 1, 0, 1, 1, "R9");
    step(2'b10, 2'b11, 0, 0, 1, 0, "R9");
    // R1: asynchronous reset between edges
    #1;
    trst_n = 1'b0;
    #2;
    sr_m = 3'b000; upd_m = 3'b000;
    route_mode = 2'b01;
    push("R1 async");
    step(2'b10, 2'b00, 0, 0, 1, 0, "R1");
    trst_n = 1'b1;
    #1;
    step(2'b01, 2'b00, 0, 0, 0, 0, "R1");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge tck);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule